// File: doc/BRIEF.md
# Periodic Interval Timer with Sticky Event Flag

This block runs a binary counter that never stops and turns it into a periodic interrupt. A 3-bit interval select picks one of eight counter bits, spaced a fixed number of bits apart. Each time the chosen bit goes from 1 to 0, one interval has passed, and an event flag is set. An interrupt request goes out whenever the event flag and the enable bit are both set.

Software reaches the block through one 16-bit control word. The port has a write strobe, a read strobe and a read-modify-write qualifier. The event flag follows a special access rule. A write of 1 to the flag does nothing, so only a write of 0 clears it. A read that is part of a read-modify-write access always shows the flag as 1. Because of this, a bit operation on another field writes the flag back as 1 and cannot clear an event by accident.

Top module: `tbt_timer`

## Requirements
- R1: Reset (synchronous, active high) clears the counter and every stored control field to 0 and holds `irq` low. After reset is released, the first interval event with select 0 comes when the counter reaches 2^(TAP_BASE+1).
- R2: The control word has this layout: bit 15 is the event flag, bit 14 is the interrupt enable, bits 13:11 are the interval select, and bits 10:8 are spare read/write storage with no behaviour. Bits 7:0 always read as 0. Writes take effect at the clock edge. Reads are combinational and return 0 while `rd_en` is low.
- R3: Writing 0 to bit 15 clears the event flag. Writing 1 to bit 15 leaves the flag unchanged, so a write can never set the flag.
- R4: A read with `rd_en` and `rmw` both high returns 1 in bit 15, whatever the flag holds. The other bits return their true values.
- R5: `irq` is high exactly while both the event flag and the enable bit are 1.
- R6: Select value n watches counter bit TAP_BASE+TAP_STEP*n (by default bit 12+2n of a 27-bit counter). The flag is set on the clock edge where that bit falls, which is once every 2^(TAP_BASE+TAP_STEP*n+1) cycles.
- R7: If an interval event and a write of 0 to the flag happen on the same edge, the set wins and the flag ends at 1.
- R8: Changing the interval select does not restart the counter. The next event comes on the new bit's falling edge, in the counter's existing phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| rd_en | input | 1 | Read strobe for the control word |
| rmw | input | 1 | Marks the current read as part of a read-modify-write access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (combinational) |
| irq | output | 1 | Interval interrupt request |

## Verification
First, a table of register accesses is walked with the slowest interval selected. This pairs normal and read-modify-write reads with writes that carry 1 or 0 in the flag position and junk in the low byte. It separates the real flag value from the forced read value, and stored bits from discarded ones. Next, the two fastest intervals are timed from one flag set to the next. The period and the phase against a counter model in the bench show which tap is wired to which select value. Clears are then placed at chosen phases. A clear far from an event must stick, while a clear on the event edge must lose, which shows the set-over-clear priority. A select change made in the middle of a period shows whether the counter keeps running or restarts. A reset in the middle of the run checks that the counter phase and the fields start again from zero.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

    localparam int REG_W     = 16;
    localparam int SEL_W     = 3;
    localparam int SEL_N     = 1 << SEL_W;
    localparam int SPARE_W   = 3;
    localparam int FLAG_BIT  = 15;
    localparam int EN_BIT    = 14;
    localparam int SEL_LSB   = 11;
    localparam int SPARE_LSB = 8;

    typedef struct packed {
        logic               flag;
        logic               en;
        logic [SEL_W-1:0]   sel;
        logic [SPARE_W-1:0] spare;
    } ctrl_t;

    // Counter bit watched for a given select value.
    function automatic int tap_of(input int base, input int step, input int n);
        return base + step * n;
    endfunction

    // Build the visible control word; a read-modify-write read forces the flag high.
    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c, input logic force_flag);
        logic [REG_W-1:0] v;
        v = '0;
        v[FLAG_BIT]                      = c.flag | force_flag;
        v[EN_BIT]                        = c.en;
        v[SEL_LSB +: SEL_W]              = c.sel;
        v[SPARE_LSB +: SPARE_W]          = c.spare;
        return v;
    endfunction

endpackage

// File: rtl/tbt_counter.sv
module tbt_counter #(
    parameter int W = 27
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] cnt_o
);

    always_ff @(posedge clk) begin
        if (rst) cnt_o <= '0;
        else     cnt_o <= cnt_o + W'(1);
    end

endmodule

// File: rtl/tbt_tap_event.sv
module tbt_tap_event
    import tbt_pkg::*;
#(
    parameter int CNT_W    = 27,
    parameter int TAP_BASE = 12,
    parameter int TAP_STEP = 2
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    // A tap bit falls on the edge where the counter bits up to and including
    // it are all ones; predicting that edge avoids storing any past tap value.
    logic [SEL_N-1:0] wrap;

    for (genvar i = 0; i < SEL_N; i++) begin : g_tap
        localparam int T = tap_of(TAP_BASE, TAP_STEP, i);
        assign wrap[i] = &cnt_i[T:0];
    end

    assign tick_o = wrap[sel_i];

endmodule

// File: rtl/tbt_ctrl_reg.sv
module tbt_ctrl_reg
    import tbt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata_hi,
    input  logic       tick,
    output ctrl_t      ctrl_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o <= '0;
        end else begin
            if (wr_en) begin
                ctrl_o.en    <= wdata_hi[EN_BIT-8];
                ctrl_o.sel   <= wdata_hi[SEL_LSB-8 +: SEL_W];
                ctrl_o.spare <= wdata_hi[SPARE_LSB-8 +: SPARE_W];
                if (!wdata_hi[FLAG_BIT-8]) ctrl_o.flag <= 1'b0;
            end
            // Event set is placed last so it overrides a same-edge clear.
            if (tick) ctrl_o.flag <= 1'b1;
        end
    end

endmodule

// File: rtl/tbt_timer.sv
module tbt_timer
    import tbt_pkg::*;
#(
    parameter int TAP_BASE = 12,
    parameter int TAP_STEP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              rmw,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              irq
);

    localparam int CNT_W = tap_of(TAP_BASE, TAP_STEP, SEL_N - 1) + 1;

    logic [CNT_W-1:0] cnt;
    logic             tick;
    ctrl_t            ctrl_q;
    logic             unused_low;

    assign unused_low = ^wdata[7:0];

    tbt_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .cnt_o (cnt)
    );

    tbt_tap_event #(
        .CNT_W    (CNT_W),
        .TAP_BASE (TAP_BASE),
        .TAP_STEP (TAP_STEP)
    ) u_tap (
        .cnt_i  (cnt),
        .sel_i  (ctrl_q.sel),
        .tick_o (tick)
    );

    tbt_ctrl_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wdata_hi (wdata[15:8]),
        .tick     (tick),
        .ctrl_o   (ctrl_q)
    );

    assign rdata = rd_en ? pack_ctrl(ctrl_q, rmw) : '0;
    assign irq   = ctrl_q.flag & ctrl_q.en;

endmodule

// File: rtl/tbt_timer_chk.sv
module tbt_timer_chk #(
    parameter int CNT_W = 27
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic             rmw,
    input logic [15:0]      wdata,
    input logic [15:0]      rdata,
    input logic             irq,
    input logic             flag,
    input logic             en,
    input logic             tick,
    input logic [CNT_W-1:0] cnt
);

    p_rst_clear_r1: assert property (@(posedge clk)
        rst |=> (!flag && !en && cnt == '0 && !irq));

    p_low_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rdata[7:0] == 8'h00);

    p_idle_read_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rdata == 16'h0000);

    p_flag_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (flag && !(wr_en && !wdata[15])) |=> flag);

    p_flag_noset_r3: assert property (@(posedge clk) disable iff (rst)
        (!flag && !tick) |=> !flag);

    p_rmw_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rmw) |-> rdata[15]);

    p_irq_gate_r5: assert property (@(posedge clk) disable iff (rst)
        !en |-> !irq);

    p_irq_follow_r5: assert property (@(posedge clk) disable iff (rst)
        (flag && en) |-> irq);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        tick |=> flag);

    p_cnt_free_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cnt == $past(cnt) + CNT_W'(1));

endmodule

bind tbt_timer tbt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .rmw   (rmw),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq),
    .flag  (ctrl_q.flag),
    .en    (ctrl_q.en),
    .tick  (tick),
    .cnt   (cnt)
);

// File: tb/tbt_timer_test.sv
module tbt_timer_test;

    localparam int BASE = 2;
    localparam int STEP = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b1;
    logic        rmw = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int          errors = 0;
    int          checks = 0;
    logic [31:0] cyc;

    always #5 clk = ~clk;

    // Reference model of the free-running counter value.
    always @(posedge clk) begin
        if (rst) cyc <= '0;
        else     cyc <= cyc + 32'd1;
    end

    tbt_timer #(.TAP_BASE(BASE), .TAP_STEP(STEP)) uut (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .rmw   (rmw),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    // {write, rmw read, write data, expected read}
    localparam int NV = 6;
    localparam logic [33:0] VEC [NV] = '{
        {1'b1, 1'b0, 16'h7F00, 16'h7F00},
        {1'b0, 1'b1, 16'h0000, 16'hFF00},
        {1'b1, 1'b0, 16'h3800, 16'h3800},
        {1'b1, 1'b0, 16'hB8FF, 16'h3800},
        {1'b0, 1'b1, 16'h0000, 16'hB800},
        {1'b1, 1'b0, 16'h7A00, 16'h7A00}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Called just after a falling edge; the write lands on the next rising edge.
    task automatic do_write(input logic [15:0] d);
        wr_en = 1'b1;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic wait_phase_write(input int m, input int r, input logic [15:0] d);
        do begin
            @(negedge clk);
            #1;
        end while ((cyc % m) != r);
        do_write(d);
    endtask

    task automatic wait_flag(output logic [31:0] c);
        c = '1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            #1;
            if (rdata[15]) begin
                c = cyc;
                return;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] c1, c2, c3;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check(rdata == 16'h0000, "R1 reset read", rdata, 16'h0000);
        check(irq == 1'b0, "R1 reset irq", irq, 0);
        rst = 1'b0;
        @(negedge clk);
        #1;

        // Table: register accesses with the slowest interval selected
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][33]) do_write(VEC[v][31:16]);
            else begin
                @(negedge clk);
                #1;
            end
            rmw = VEC[v][32];
            #1;
            // R2 field layout, R3 write-1 ignored, R4 rmw read forces flag
            check(rdata == VEC[v][15:0], VEC[v][32] ? "R4 rmw read" : "R2/R3 stored word",
                  rdata, VEC[v][15:0]);
            check(irq == 1'b0, "R5 irq low while flag clear", irq, 0);
            rmw = 1'b0;
            #1;
        end

        // R6: select 0, period 2^(BASE+1)
        do_write(16'h4000);
        wait_flag(c1);
        check((c1 % 8) == 0, "R6 sel0 phase", c1, 0);
        check(irq == 1'b1, "R5 irq with flag and enable", irq, 1);
        do_write(16'h4000);
        wait_flag(c2);
        check((c2 - c1) == 8, "R6 sel0 period", c2 - c1, 8);

        // R3: clear away from an event sticks
        wait_phase_write(8, 3, 16'h4000);
        check(rdata[15] == 1'b0, "R3 clear by writing 0", rdata[15], 0);
        check(irq == 1'b0, "R5 irq drops with flag", irq, 0);

        // R7: clear on the event edge loses
        wait_phase_write(8, 7, 16'h4000);
        check(rdata[15] == 1'b1, "R7 set wins over clear", rdata[15], 1);

        // R5: enable gating
        do_write(16'h8000);
        check(rdata == 16'h8000, "R3 write 1 keeps flag", rdata, 16'h8000);
        check(irq == 1'b0, "R5 irq off when disabled", irq, 0);
        do_write(16'hC000);
        check(irq == 1'b1, "R5 irq on when enabled", irq, 1);

        // R6: select 1, period 2^(BASE+STEP+1)
        do_write(16'h4800);
        wait_flag(c1);
        check((c1 % 32) == 0, "R6 sel1 phase", c1 % 32, 0);
        do_write(16'h4800);
        wait_flag(c2);
        check((c2 - c1) == 32, "R6 sel1 period", c2 - c1, 32);

        // R8: select change mid-period keeps counter phase
        wait_phase_write(32, 9, 16'h4000);
        wait_flag(c3);
        check((c3 % 32) == 16, "R8 new tap in old phase", c3 % 32, 16);

        // R1: reset mid-run restarts counter and clears fields
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #1;
        check(rdata == 16'h0000, "R1 mid-run reset read", rdata, 16'h0000);
        check(irq == 1'b0, "R1 mid-run reset irq", irq, 0);
        rst = 1'b0;
        wait_flag(c1);
        check(c1 == 32'd8, "R1 counter restarts from zero", c1, 8);
        check(irq == 1'b0, "R1 enable cleared by reset", irq, 0);

        finish_run();
    end

endmodule